// File: doc/BRIEF.md
# Pixel-Count Display Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and pixel-position strobes for a parallel panel port, and forms the output colour for every pixel clock. Horizontal timing is counted per line. Vertical timing is counted in pixel clocks across the whole frame. The vertical sync length and the vertical display window are therefore programmed as absolute pixel offsets within the frame, which is the line count multiplied by the line period. An added skew shifts the vertical window.

The timing and colour settings are sampled once, when the block leaves its idle state. During the display window it passes upstream pixels through. When upstream data is missing and recovery is enabled, it substitutes an underflow colour. Outside the window it drives a border colour. Dropping the enable does not stop output at once: the current frame runs to its end first. A one-cycle frame-start pulse marks the first pixel of every frame and can serve as the vertical interrupt source.

Top module: `pixcnt_timing_gen`

## Requirements
- R1: While running, the line position `h_pos_o` counts 0 to `h_period_i`-1 and wraps. Horizontal sync is active while the line position is below `h_pulse_i`.
- R2: While running, the frame position `f_pos_o` counts 0 to `v_period_i`-1 and wraps, with the line position also returning to 0. Vertical sync is active while the frame position is below `v_pulse_i`.
- R3: `hs_low_i`=1 makes horizontal sync active-low, and `vs_low_i`=1 does the same for vertical sync. A value of 0 means active-high. When idle, each sync sits at its inactive level.
- R4: `de_o` is high only when the line position lies in [`h_start_i`, `h_end_i`] and the frame position lies in [`v_start_i`+`skew_i`, `v_end_i`+`skew_i`]. Both ranges are inclusive.
- R5: When `de_o` is high and `pix_valid_i` was high, `rgb_o` equals the `pix_i` sampled for that position.
- R6: When `de_o` is high and `pix_valid_i` was low, `rgb_o` is `uflow_rgb_i` if `uflow_rec_i`=1. If `uflow_rec_i`=0, `rgb_o` is the raw `pix_i`.
- R7: When `de_o` is low, `rgb_o` is `border_rgb_i`.
- R8: `frame_start_o` is high for exactly the one cycle in which `f_pos_o` is 0, in every frame including the first.
- R9: Clearing `en_i` stops output only after the last position of the current frame has been emitted. Setting `en_i` again before that point does not cancel the stop. After the stop, `de_o` and `frame_start_o` are 0, the positions are 0 and the syncs are inactive, for at least one cycle.
- R10: All settings are captured when the block starts from idle. Changes to the setting inputs while running have no effect until the next start.
- R11: During and after reset, with enable low, the block is idle and all outputs are 0.
- R12: `en_i` is first sampled high in idle on edge E0. The outputs for frame position 0 appear after edge E1, and the outputs after E0 are still idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run request |
| h_period_i | input | 12 | Line period in pixel clocks |
| h_pulse_i | input | 12 | Horizontal sync width |
| h_start_i | input | 12 | First displayed line position |
| h_end_i | input | 12 | Last displayed line position |
| skew_i | input | 12 | Offset added to both vertical window bounds |
| v_period_i | input | 24 | Frame period in pixel clocks |
| v_pulse_i | input | 24 | Vertical sync length in pixel clocks |
| v_start_i | input | 24 | First displayed frame position before skew |
| v_end_i | input | 24 | Last displayed frame position before skew |
| hs_low_i | input | 1 | Horizontal sync active-low select |
| vs_low_i | input | 1 | Vertical sync active-low select |
| uflow_rec_i | input | 1 | Underflow recovery enable |
| border_rgb_i | input | 24 | Colour outside the display window |
| uflow_rgb_i | input | 24 | Colour shown on missing input |
| pix_i | input | 24 | Upstream pixel |
| pix_valid_i | input | 1 | Upstream pixel present |
| pix_req_o | output | 1 | Current position is in the display window; pixel is sampled this cycle |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| frame_start_o | output | 1 | First pixel of frame |
| h_pos_o | output | 12 | Line position of current output |
| f_pos_o | output | 24 | Frame position of current output |
| rgb_o | output | 24 | Output colour |

## Verification
Two events can coincide: a stop request that arrives while the block is already stopping, and the frame wrap that ends the stop. The bench drops the enable in mid-frame, raises it again two cycles later, and checks every position through to the end of that frame against a model. It then requires exactly one idle cycle before position 0 reappears, and that cycle must use the settings captured at the restart. A second case checks that a missing pixel and the last position of the display window can be handled in the same cycle: the window end is placed on the final line position and the final frame position, and the pixel there is made invalid while recovery is off.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    parameter int unsigned PTG_HW = 12;
    parameter int unsigned PTG_FW = 24;
    parameter int unsigned PTG_PW = 24;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2
    } run_st_e;

    typedef struct packed {
        logic [PTG_HW-1:0] h_period;
        logic [PTG_HW-1:0] h_pulse;
        logic [PTG_HW-1:0] h_start;
        logic [PTG_HW-1:0] h_end;
        logic [PTG_HW-1:0] skew;
        logic [PTG_FW-1:0] v_period;
        logic [PTG_FW-1:0] v_pulse;
        logic [PTG_FW-1:0] v_start;
        logic [PTG_FW-1:0] v_end;
        logic              hs_low;
        logic              vs_low;
        logic              uf_rec;
        logic [PTG_PW-1:0] border;
        logic [PTG_PW-1:0] uf_col;
    } tcfg_t;

    typedef struct packed {
        logic              hsync;
        logic              vsync;
        logic              de;
        logic              fstart;
        logic [PTG_HW-1:0] hpos;
        logic [PTG_FW-1:0] fpos;
        logic [PTG_PW-1:0] rgb;
    } tout_t;

    function automatic logic in_span_f(input logic [PTG_FW-1:0] v,
                                       input logic [PTG_FW-1:0] lo,
                                       input logic [PTG_FW-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction
endpackage

// File: rtl/ptg_ctrl.sv
module ptg_ctrl
    import ptg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_i,
    input  tcfg_t cfg_in_i,
    input  logic  last_i,
    output tcfg_t cfg_o,
    output logic  run_o
);
    run_st_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg_o <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (en_i) begin
                        state <= ST_RUN;
                        cfg_o <= cfg_in_i;
                    end
                end
                ST_RUN: begin
                    if (!en_i && last_i)  state <= ST_IDLE;
                    else if (!en_i)       state <= ST_STOP;
                end
                ST_STOP: begin
                    if (last_i)           state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign run_o = (state != ST_IDLE);

    // R9: a pending stop is never cancelled
    p_stop_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP) |=> (state != ST_RUN));
    // R9: leaving the running states happens only at the frame boundary
    p_stop_at_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && !last_i) |=> (state != ST_IDLE));
    // R10: captured settings hold while running
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(cfg_o));
endmodule

// File: rtl/ptg_counters.sv
module ptg_counters #(
    parameter int unsigned HW = ptg_pkg::PTG_HW,
    parameter int unsigned FW = ptg_pkg::PTG_FW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic [HW-1:0] h_period_i,
    input  logic [FW-1:0] v_period_i,
    output logic [HW-1:0] h_cnt_o,
    output logic [FW-1:0] f_cnt_o,
    output logic          last_o
);
    localparam logic [HW-1:0] H_ONE = HW'(1);
    localparam logic [FW-1:0] F_ONE = FW'(1);

    logic h_wrap;

    assign last_o = run_i && (f_cnt_o == v_period_i - F_ONE);
    assign h_wrap = (h_cnt_o == h_period_i - H_ONE);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            h_cnt_o <= '0;
            f_cnt_o <= '0;
        end else if (last_o) begin
            h_cnt_o <= '0;
            f_cnt_o <= '0;
        end else begin
            f_cnt_o <= f_cnt_o + F_ONE;
            h_cnt_o <= h_wrap ? '0 : h_cnt_o + H_ONE;
        end
    end

    // R1: line position stays inside the line period
    p_hcnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (h_cnt_o < h_period_i));
    // R2: frame position advances by one until the wrap
    p_fcnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        (run_i && !last_o) |=> (f_cnt_o == $past(f_cnt_o) + F_ONE));
endmodule

// File: rtl/ptg_output.sv
module ptg_output
    import ptg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  tcfg_t             cfg_i,
    input  logic [PTG_HW-1:0] h_cnt_i,
    input  logic [PTG_FW-1:0] f_cnt_i,
    input  logic [PTG_PW-1:0] pix_i,
    input  logic              pix_valid_i,
    output logic              pix_req_o,
    output tout_t             out_o
);
    logic              h_win, v_win, act, hs_act, vs_act;
    logic [PTG_FW-1:0] v_lo, v_hi;
    logic [PTG_PW-1:0] rgb_n;

    assign v_lo   = cfg_i.v_start + PTG_FW'(cfg_i.skew);
    assign v_hi   = cfg_i.v_end   + PTG_FW'(cfg_i.skew);
    assign h_win  = (h_cnt_i >= cfg_i.h_start) && (h_cnt_i <= cfg_i.h_end);
    assign v_win  = in_span_f(f_cnt_i, v_lo, v_hi);
    assign act    = run_i && h_win && v_win;
    assign hs_act = run_i && (h_cnt_i < cfg_i.h_pulse);
    assign vs_act = run_i && (f_cnt_i < cfg_i.v_pulse);
    assign pix_req_o = act;

    always_comb begin
        if (!act)                           rgb_n = cfg_i.border;
        else if (pix_valid_i || !cfg_i.uf_rec) rgb_n = pix_i;
        else                                rgb_n = cfg_i.uf_col;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_o <= '0;
        end else begin
            out_o.hsync  <= hs_act ^ cfg_i.hs_low;
            out_o.vsync  <= vs_act ^ cfg_i.vs_low;
            out_o.de     <= act;
            out_o.fstart <= run_i && (f_cnt_i == '0);
            out_o.hpos   <= h_cnt_i;
            out_o.fpos   <= f_cnt_i;
            out_o.rgb    <= rgb_n;
        end
    end

    // R8: frame-start only accompanies position zero
    p_fstart_pos_r8: assert property (@(posedge clk) disable iff (rst)
        out_o.fstart |-> (out_o.fpos == '0));
    // R6: a missing pixel under recovery shows the underflow colour
    p_uflow_r6: assert property (@(posedge clk) disable iff (rst)
        (act && !pix_valid_i && cfg_i.uf_rec) |=> (out_o.rgb == $past(cfg_i.uf_col)));
    // R9: nothing is displayed once idle
    p_idle_no_de_r9: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !out_o.de);
endmodule

// File: rtl/pixcnt_timing_gen.sv
module pixcnt_timing_gen
    import ptg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [PTG_HW-1:0] h_period_i,
    input  logic [PTG_HW-1:0] h_pulse_i,
    input  logic [PTG_HW-1:0] h_start_i,
    input  logic [PTG_HW-1:0] h_end_i,
    input  logic [PTG_HW-1:0] skew_i,
    input  logic [PTG_FW-1:0] v_period_i,
    input  logic [PTG_FW-1:0] v_pulse_i,
    input  logic [PTG_FW-1:0] v_start_i,
    input  logic [PTG_FW-1:0] v_end_i,
    input  logic              hs_low_i,
    input  logic              vs_low_i,
    input  logic              uflow_rec_i,
    input  logic [PTG_PW-1:0] border_rgb_i,
    input  logic [PTG_PW-1:0] uflow_rgb_i,
    input  logic [PTG_PW-1:0] pix_i,
    input  logic              pix_valid_i,
    output logic              pix_req_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              frame_start_o,
    output logic [PTG_HW-1:0] h_pos_o,
    output logic [PTG_FW-1:0] f_pos_o,
    output logic [PTG_PW-1:0] rgb_o
);
    tcfg_t             cfg_in, cfg;
    tout_t             outq;
    logic              run, last;
    logic [PTG_HW-1:0] h_cnt;
    logic [PTG_FW-1:0] f_cnt;

    always_comb begin
        cfg_in.h_period = h_period_i;
        cfg_in.h_pulse  = h_pulse_i;
        cfg_in.h_start  = h_start_i;
        cfg_in.h_end    = h_end_i;
        cfg_in.skew     = skew_i;
        cfg_in.v_period = v_period_i;
        cfg_in.v_pulse  = v_pulse_i;
        cfg_in.v_start  = v_start_i;
        cfg_in.v_end    = v_end_i;
        cfg_in.hs_low   = hs_low_i;
        cfg_in.vs_low   = vs_low_i;
        cfg_in.uf_rec   = uflow_rec_i;
        cfg_in.border   = border_rgb_i;
        cfg_in.uf_col   = uflow_rgb_i;
    end

    ptg_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en_i),
        .cfg_in_i (cfg_in),
        .last_i   (last),
        .cfg_o    (cfg),
        .run_o    (run)
    );

    ptg_counters #(.HW(PTG_HW), .FW(PTG_FW)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .run_i      (run),
        .h_period_i (cfg.h_period),
        .v_period_i (cfg.v_period),
        .h_cnt_o    (h_cnt),
        .f_cnt_o    (f_cnt),
        .last_o     (last)
    );

    ptg_output u_out (
        .clk         (clk),
        .rst         (rst),
        .run_i       (run),
        .cfg_i       (cfg),
        .h_cnt_i     (h_cnt),
        .f_cnt_i     (f_cnt),
        .pix_i       (pix_i),
        .pix_valid_i (pix_valid_i),
        .pix_req_o   (pix_req_o),
        .out_o       (outq)
    );

    assign hsync_o       = outq.hsync;
    assign vsync_o       = outq.vsync;
    assign de_o          = outq.de;
    assign frame_start_o = outq.fstart;
    assign h_pos_o       = outq.hpos;
    assign f_pos_o       = outq.fpos;
    assign rgb_o         = outq.rgb;
endmodule

// File: tb/pixcnt_timing_gen_bench.sv
module pixcnt_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b0;
    logic [11:0] h_period_i = '0, h_pulse_i = '0, h_start_i = '0, h_end_i = '0, skew_i = '0;
    logic [23:0] v_period_i = '0, v_pulse_i = '0, v_start_i = '0, v_end_i = '0;
    logic        hs_low_i = 1'b0, vs_low_i = 1'b0, uflow_rec_i = 1'b0;
    logic [23:0] border_rgb_i = '0, uflow_rgb_i = '0, pix_i = '0;
    logic        pix_valid_i = 1'b0;
    logic        pix_req_o, hsync_o, vsync_o, de_o, frame_start_o;
    logic [11:0] h_pos_o;
    logic [23:0] f_pos_o, rgb_o;

    pixcnt_timing_gen u_pixcnt_timing_gen (.*);

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    // active (captured) settings as the bench expects them
    int a_hp, a_hpl, a_hs, a_he, a_sk, a_vp, a_vpl, a_vs, a_ve;
    bit a_hsl, a_vsl, a_rec;
    logic [23:0] a_bord, a_ucol;
    int ef = 0;
    int pmode = 0;
    int pcnt = 0;
    logic [23:0] prev_pix = '0;
    logic prev_val = 1'b0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (fpos %0d)", tag, got, exp, ef);
        end
    endtask

    task automatic apply_cfg(input int hp, hpl, hs, he, sk, vp, vpl, vs, ve,
                             input bit hsl, vsl, rec, input logic [23:0] bord, ucol);
        h_period_i = 12'(hp); h_pulse_i = 12'(hpl); h_start_i = 12'(hs); h_end_i = 12'(he);
        skew_i = 12'(sk); v_period_i = 24'(vp); v_pulse_i = 24'(vpl);
        v_start_i = 24'(vs); v_end_i = 24'(ve);
        hs_low_i = hsl; vs_low_i = vsl; uflow_rec_i = rec;
        border_rgb_i = bord; uflow_rgb_i = ucol;
    endtask

    task automatic latch_expect();
        a_hp = int'(h_period_i); a_hpl = int'(h_pulse_i); a_hs = int'(h_start_i);
        a_he = int'(h_end_i); a_sk = int'(skew_i); a_vp = int'(v_period_i);
        a_vpl = int'(v_pulse_i); a_vs = int'(v_start_i); a_ve = int'(v_end_i);
        a_hsl = hs_low_i; a_vsl = vs_low_i; a_rec = uflow_rec_i;
        a_bord = border_rgb_i; a_ucol = uflow_rgb_i;
    endtask

    task automatic drive_pix();
        pcnt++;
        pix_i = {8'h5A, 16'(pcnt)};
        pix_valid_i = (pmode == 0) ? 1'b1 : ((pcnt % 3) != 0);
        prev_pix = pix_i;
        prev_val = pix_valid_i;
    endtask

    // compares all outputs for ncyc cycles; entered and left at a negedge
    task automatic run_check(input int ncyc);
        for (int k = 0; k < ncyc; k++) begin
            int h;
            bit de_e;
            logic [23:0] rgb_e;
            string rtag;
            h = ef % a_hp;
            de_e = (h >= a_hs) && (h <= a_he) && (ef >= a_vs + a_sk) && (ef <= a_ve + a_sk);
            if (!de_e) begin rgb_e = a_bord; rtag = "R7"; end
            else if (prev_val) begin rgb_e = prev_pix; rtag = "R5"; end
            else begin rgb_e = a_rec ? a_ucol : prev_pix; rtag = "R6"; end
            chk("R1 hpos", 32'(h_pos_o), 32'(h));
            chk("R2 fpos", 32'(f_pos_o), 32'(ef));
            chk(a_hsl ? "R3 hsync" : "R1 hsync", 32'(hsync_o), 32'((h < a_hpl) ^ a_hsl));
            chk(a_vsl ? "R3 vsync" : "R2 vsync", 32'(vsync_o), 32'((ef < a_vpl) ^ a_vsl));
            chk("R4 de", 32'(de_o), 32'(de_e));
            chk(rtag, 32'(rgb_o), 32'(rgb_e));
            chk("R8 fstart", 32'(frame_start_o), 32'(ef == 0));
            drive_pix();
            @(negedge clk);
            ef = (ef + 1) % a_vp;
        end
    endtask

    task automatic check_idle(input string tag);
        chk(tag, 32'(de_o), 32'd0);
        chk(tag, 32'(frame_start_o), 32'd0);
        chk(tag, 32'(f_pos_o), 32'd0);
        chk(tag, 32'(h_pos_o), 32'd0);
        chk(tag, 32'(hsync_o), 32'(a_hsl));
        chk(tag, 32'(vsync_o), 32'(a_vsl));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R11 during reset", 32'({hsync_o, vsync_o, de_o, frame_start_o}), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 after reset", 32'({hsync_o, vsync_o, de_o, frame_start_o}), 32'd0);
        chk("R11 rgb", 32'(rgb_o), 32'd0);
        chk("R11 pos", 32'(f_pos_o), 32'd0);
    endtask

    task automatic t_start_and_frames();
        apply_cfg(10, 2, 3, 8, 3, 60, 10, 20, 49, 1'b0, 1'b0, 1'b1, 24'h000000, 24'h0000FF);
        latch_expect();
        pmode = 0;
        en_i = 1'b1;
        drive_pix();
        @(negedge clk);
        chk("R12 after E0 fstart", 32'(frame_start_o), 32'd0);
        chk("R12 after E0 de", 32'(de_o), 32'd0);
        drive_pix();
        @(negedge clk);
        chk("R12 after E1 fstart", 32'(frame_start_o), 32'd1);
        ef = 0;
        run_check(120);
    endtask

    task automatic t_underflow_and_ignore();
        // new settings on the inputs while running must not take effect
        apply_cfg(8, 1, 2, 7, 0, 40, 16, 16, 39, 1'b1, 1'b1, 1'b0, 24'h123456, 24'h00FF00);
        pmode = 1;
        run_check(25);
        chk("R10 old line period kept", 32'(h_pos_o), 32'(ef % 10));
        chk("R10 old polarity kept", 32'(hsync_o), 32'((ef % 10) < 2));
        run_check(20);
    endtask

    task automatic t_stop_resume();
        en_i = 1'b0;
        run_check(2);
        en_i = 1'b1;
        run_check(a_vp - ef);
        check_idle("R9 one idle cycle");
        latch_expect();
        drive_pix();
        @(negedge clk);
        ef = 0;
        chk("R10 new period on restart", 32'(frame_start_o), 32'd1);
        chk("R10 new polarity on restart", 32'(hsync_o), 32'd0);
        run_check(80);
    endtask

    task automatic t_final_stop();
        run_check(5);
        en_i = 1'b0;
        run_check(a_vp - ef);
        for (int k = 0; k < 3; k++) begin
            check_idle("R9 stays idle");
            chk("R7 idle border", 32'(rgb_o), 32'(a_bord));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_start_and_frames();
        t_underflow_and_ignore();
        t_stop_resume();
        t_final_stop();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule